// File: doc/BRIEF.md
# Automatic Phase Shedding Controller

This block decides which phases of a multiphase buck regulator are switching. It follows the voltage-identification (VID) code the load requests: when a new code asks for a lower voltage, the block treats this as the load entering a light-load state and drops to one or two phases. When a later code asks for a higher voltage, it restores the full configured phase count. The VID bus and an active-low force input are asynchronous. Each passes through a two-flop synchronizer, and shedding decisions are taken only on the synchronized values.

The direction of a VID step is judged on decoded voltage levels, not raw codes. The block supports two code formats, chosen by a select input. An auto-enable input gates the VID-driven behaviour. The force input overrides it and puts the regulator into the low-power state whatever the VID history is.

Alongside the phase enable mask, the block reports the low-power state. It also produces a current-limit threshold scaled by the ratio of running phases to configured phases, so the total limit follows the phases that remain.

Top module: `phase_shed_ctrl`

## Requirements
- R1: While `rst_ni` is low, `low_power_o` is 0, `phase_en_o` is the full configured mask and `ilim_o` equals `ILIM_FULL`.
- R2: With `auto_en_i` high, a change of the synchronized VID to a lower decoded voltage sets `low_power_o` three clock edges after the new code is first sampled.
- R3: A change of the synchronized VID to a higher decoded voltage clears the automatic low-power state with the same three-edge latency.
- R4: While `auto_en_i` is low, VID steps never cause shedding, and an existing automatic low-power state is dropped on the next edge.
- R5: `force_lp_ni` low sets `low_power_o` two edges later, whatever the state of `auto_en_i` and the VID history; releasing it returns control to the automatic state.
- R6: In the low-power state, `one_phase_i` high gives mask 4'b0001 (phase 1 only) and low gives 4'b0101 (phases 1 and 3).
- R7: Outside the low-power state, `cfg_phases_i` = 2 gives 4'b0101, 3 gives 4'b0111, and any other value means four phases, 4'b1111. Bit 0 is phase 1, and phase 1 is always enabled.
- R8: `ilim_o` equals floor(`ILIM_FULL` x running / configured), where running is the number of mask bits set.
- R9: `vid_fmt_i` = 0 selects the 8-bit format: code 0 or 1 decodes to 0 V, and code c of 2 or more decodes to 1.6125 V - (c-2) x 6.25 mV, so a larger code means a lower voltage. `vid_fmt_i` = 1 selects the 6-bit format: only bits 5:0 count, code c decodes to 1.55 V - c x 25 mV, and 62 and 63 decode to 0 V. A change confined to bits 7:6 is no transition.
- R10: A step to a code that decodes to 0 V counts as a step to a lower voltage.
- R11: While the decoded VID is unchanged, the low-power state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vid_i | input | 8 | Asynchronous VID code |
| vid_fmt_i | input | 1 | VID format: 0 = 8-bit, 1 = 6-bit |
| cfg_phases_i | input | 3 | Configured phase count (2, 3, otherwise 4) |
| auto_en_i | input | 1 | Enables VID-driven shedding |
| force_lp_ni | input | 1 | Asynchronous active-low forced low-power request |
| one_phase_i | input | 1 | Phases kept when shed: 1 = one, 0 = two |
| phase_en_o | output | 4 | Phase enable mask, bit 0 = phase 1 |
| low_power_o | output | 1 | Low-power (shed) state |
| ilim_o | output | ILIM_W | Scaled total current-limit threshold |

## Verification
The bound checker checks on every cycle the properties of the output side that do not depend on history: phase 1 always on, no phase outside the configured set, mask population matching the state and the phase selections, and a current limit that is full whenever nothing is shed. It also checks the two-edge force path and the clearing of the low-power state when auto mode is off. The direction of VID steps under each format, the off codes, the three-edge latency and the holding of state on unchanged codes depend on the sequence of codes. Only the bench's reference model shows these, as it replays each scenario cycle by cycle.

// File: rtl/phase_shed_pkg.sv
package phase_shed_pkg;
   localparam int VID_W   = 8;
   localparam int NUM_PH  = 4;
   localparam int LVL_W   = 13;
   // voltage levels in quarter-millivolt units
   localparam int L8_TOP  = 6450;
   localparam int L8_STEP = 25;
   localparam int L8_OFF  = 2;
   localparam int L6_TOP  = 6200;
   localparam int L6_STEP = 100;
   localparam int L6_OFF  = 62;

   typedef logic [LVL_W-1:0] lvl_t;
   typedef logic [NUM_PH-1:0] ph_mask_t;

   typedef enum logic {
      VID_FMT_8B = 1'b0,
      VID_FMT_6B = 1'b1
   } vid_fmt_e;
endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
   parameter int          W       = 8,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];

   initial begin
      assert (STAGES >= 2) else $fatal(1, "psc_sync needs at least two stages");
   end
endmodule

// File: rtl/psc_vid_decode.sv
module psc_vid_decode
   import phase_shed_pkg::*;
#(
   parameter bit ALLOW_6B = 1'b1
) (
   input  logic [VID_W-1:0] code_i,
   input  logic             fmt_i,
   output lvl_t             lvl_o
);
   vid_fmt_e fmt;
   lvl_t     lvl8;
   assign fmt = vid_fmt_e'(fmt_i);

   always_comb begin
      if (int'(code_i) < L8_OFF) lvl8 = '0;
      else lvl8 = LVL_W'(L8_TOP - L8_STEP * (int'(code_i) - L8_OFF));
   end

   if (ALLOW_6B) begin : g_two_fmt
      lvl_t lvl6;
      always_comb begin
         if (int'(code_i[5:0]) >= L6_OFF) lvl6 = '0;
         else lvl6 = LVL_W'(L6_TOP - L6_STEP * int'(code_i[5:0]));
      end
      assign lvl_o = (fmt == VID_FMT_6B) ? lvl6 : lvl8;
   end else begin : g_one_fmt
      logic unused_fmt;
      assign unused_fmt = fmt_i;
      assign lvl_o = lvl8;
   end
endmodule

// File: rtl/psc_shed_state.sv
module psc_shed_state
   import phase_shed_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [VID_W-1:0] vid_s_i,
   input  logic             fmt_i,
   input  logic             auto_en_i,
   input  logic             force_s_ni,
   output logic             low_power_o
);
   logic [VID_W-1:0] vid_cur_q;
   lvl_t             lvl_new, lvl_old;
   logic             auto_q, auto_d;

   psc_vid_decode #(.ALLOW_6B(1'b1)) u_dec_new (
      .code_i (vid_s_i),
      .fmt_i  (fmt_i),
      .lvl_o  (lvl_new)
   );

   psc_vid_decode #(.ALLOW_6B(1'b1)) u_dec_old (
      .code_i (vid_cur_q),
      .fmt_i  (fmt_i),
      .lvl_o  (lvl_old)
   );

   always_comb begin
      auto_d = auto_q;
      if (!auto_en_i)             auto_d = 1'b0;
      else if (lvl_new < lvl_old) auto_d = 1'b1;
      else if (lvl_new > lvl_old) auto_d = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vid_cur_q <= '0;
         auto_q    <= 1'b0;
      end else begin
         vid_cur_q <= vid_s_i;
         auto_q    <= auto_d;
      end
   end

   assign low_power_o = auto_q | ~force_s_ni;
endmodule

// File: rtl/psc_phase_map.sv
module psc_phase_map
   import phase_shed_pkg::*;
#(
   parameter int ILIM_W    = 10,
   parameter int ILIM_FULL = 800
) (
   input  logic              low_power_i,
   input  logic [2:0]        cfg_phases_i,
   input  logic              one_phase_i,
   output ph_mask_t          phase_en_o,
   output logic [ILIM_W-1:0] ilim_o
);
   int       cfg_cnt, run_cnt, prod, quot;
   ph_mask_t cfg_keep, shed_keep;

   always_comb begin
      unique case (cfg_phases_i)
         3'd2:    begin cfg_cnt = 2; cfg_keep = 4'b0101; end
         3'd3:    begin cfg_cnt = 3; cfg_keep = 4'b0111; end
         default: begin cfg_cnt = 4; cfg_keep = 4'b1111; end
      endcase
      shed_keep = one_phase_i ? 4'b0001 : 4'b0101;
   end

   for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
      assign phase_en_o[p] = low_power_i ? shed_keep[p] : cfg_keep[p];
   end

   always_comb begin
      run_cnt = low_power_i ? (one_phase_i ? 1 : 2) : cfg_cnt;
      prod    = ILIM_FULL * run_cnt;
      unique case (cfg_cnt)
         2:       quot = prod / 2;
         3:       quot = prod / 3;
         default: quot = prod / 4;
      endcase
      ilim_o = ILIM_W'(quot);
   end
endmodule

// File: rtl/phase_shed_ctrl.sv
module phase_shed_ctrl
   import phase_shed_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ILIM_W      = 10,
   parameter int ILIM_FULL   = 800
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [7:0]        vid_i,
   input  logic              vid_fmt_i,
   input  logic [2:0]        cfg_phases_i,
   input  logic              auto_en_i,
   input  logic              force_lp_ni,
   input  logic              one_phase_i,
   output logic [3:0]        phase_en_o,
   output logic              low_power_o,
   output logic [ILIM_W-1:0] ilim_o
);
   logic [VID_W-1:0] vid_s;
   logic             force_s_n;

   psc_sync #(.W(VID_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_vid (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (vid_i),
      .q_o    (vid_s)
   );

   psc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_force (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (force_lp_ni),
      .q_o    (force_s_n)
   );

   psc_shed_state u_state (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .vid_s_i     (vid_s),
      .fmt_i       (vid_fmt_i),
      .auto_en_i   (auto_en_i),
      .force_s_ni  (force_s_n),
      .low_power_o (low_power_o)
   );

   psc_phase_map #(.ILIM_W(ILIM_W), .ILIM_FULL(ILIM_FULL)) u_map (
      .low_power_i  (low_power_o),
      .cfg_phases_i (cfg_phases_i),
      .one_phase_i  (one_phase_i),
      .phase_en_o   (phase_en_o),
      .ilim_o       (ilim_o)
   );

   initial begin
      assert (ILIM_FULL > 0 && ILIM_FULL < (1 << ILIM_W))
         else $fatal(1, "ILIM_FULL does not fit ILIM_W");
      assert (NUM_PH == 4) else $fatal(1, "phase map is built for four phases");
   end
endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
   parameter int ILIM_W    = 10,
   parameter int ILIM_FULL = 800
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              auto_en_i,
   input logic              force_lp_ni,
   input logic              one_phase_i,
   input logic [2:0]        cfg_phases_i,
   input logic [3:0]        phase_en_o,
   input logic              low_power_o,
   input logic [ILIM_W-1:0] ilim_o
);
   logic [1:0] age_q;
   logic [3:0] allowed;
   int         cfg_n;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           age_q <= 2'd0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   always_comb begin
      case (cfg_phases_i)
         3'd2:    begin allowed = 4'b0101; cfg_n = 2; end
         3'd3:    begin allowed = 4'b0111; cfg_n = 3; end
         default: begin allowed = 4'b1111; cfg_n = 4; end
      endcase
   end

   assert_phase1_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_en_o[0]);

   assert_cfg_subset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_en_o & ~allowed) == 4'b0000);

   assert_full_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !low_power_o |-> $countones(phase_en_o) == cfg_n);

   assert_shed_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_power_o |-> $countones(phase_en_o) == (one_phase_i ? 1 : 2));

   assert_full_ilim_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !low_power_o |-> int'(ilim_o) == ILIM_FULL);

   assert_ilim_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(ilim_o) <= ILIM_FULL);

   assert_force_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2 && !$past(force_lp_ni)) |=> low_power_o);

   assert_auto_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2 && !auto_en_i && $past(force_lp_ni)) |=> !low_power_o);
endmodule

bind phase_shed_ctrl psc_chk #(.ILIM_W(ILIM_W), .ILIM_FULL(ILIM_FULL)) i_chk (.*);

// File: tb/test_phase_shed_ctrl.sv
module test_phase_shed_ctrl;
   localparam int ILIM_W    = 10;
   localparam int ILIM_FULL = 800;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [7:0]        vid;
   logic              fmt;
   logic [2:0]        cfg;
   logic              auto_en, force_n, one_sel;
   logic [3:0]        mask;
   logic              lp;
   logic [ILIM_W-1:0] ilim;

   always #4 clk = ~clk;

   phase_shed_ctrl #(.SYNC_STAGES(2), .ILIM_W(ILIM_W), .ILIM_FULL(ILIM_FULL)) i_phase_shed_ctrl (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .vid_i        (vid),
      .vid_fmt_i    (fmt),
      .cfg_phases_i (cfg),
      .auto_en_i    (auto_en),
      .force_lp_ni  (force_n),
      .one_phase_i  (one_sel),
      .phase_en_o   (mask),
      .low_power_o  (lp),
      .ilim_o       (ilim)
   );

   int    n_chk  = 0;
   int    n_fail = 0;
   string req    = "R1";
   bit    done   = 1'b0;

   // reference model state
   int unsigned vq[$];
   bit          fq[$];
   int unsigned m_cur;
   bit          m_auto;

   function automatic int volt_uv(int unsigned code, bit six);
      int c;
      if (six) begin
         c = code % 64;
         return (c >= 62) ? 0 : 1550000 - c * 25000;
      end
      return (code < 2) ? 0 : 1612500 - (int'(code) - 2) * 6250;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         vq = {0, 0};
         fq = {1'b1, 1'b1};
         m_cur = 0;
         m_auto = 1'b0;
      end else begin : model_step
         int v_new, v_old;
         v_new = volt_uv(vq[0], fmt);
         v_old = volt_uv(m_cur, fmt);
         if (!auto_en)           m_auto = 1'b0;
         else if (v_new < v_old) m_auto = 1'b1;
         else if (v_new > v_old) m_auto = 1'b0;
         m_cur = vq[0];
         void'(vq.pop_front());
         vq.push_back(int'(vid));
         void'(fq.pop_front());
         fq.push_back(force_n);
      end
   end

   task automatic check(string r, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", r, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!done && vq.size() == 2) begin : cmp
         bit e_lp;
         int c, run, e_mask;
         e_lp = !rst_n ? 1'b0 : (m_auto || !fq[0]);
         c = (cfg == 3'd2) ? 2 : (cfg == 3'd3) ? 3 : 4;
         if (e_lp) begin
            run = one_sel ? 1 : 2;
            e_mask = one_sel ? 1 : 5;
         end else begin
            run = c;
            e_mask = (c == 2) ? 5 : (c == 3) ? 7 : 15;
         end
         check(req, "low_power", int'(lp), int'(e_lp));
         check(req, "phase_mask", int'(mask), e_mask);
         check(req, "ilim", int'(ilim), ILIM_FULL * run / c);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; vid = 8'h20; fmt = 1'b0; cfg = 3'd4;
      auto_en = 1'b1; force_n = 1'b1; one_sel = 1'b0;
      req = "R1";  step(4);
      rst_n = 1'b1; step(6);

      req = "R7";  cfg = 3'd2; step(3); cfg = 3'd3; step(3);
      cfg = 3'd5;  step(3); cfg = 3'd4; step(3);

      req = "R2";  vid = 8'h30; step(6);          // larger 8-bit code: lower voltage
      req = "R6";  one_sel = 1'b1; step(3); one_sel = 1'b0; step(3);
      req = "R8";  cfg = 3'd3; step(3); one_sel = 1'b1; step(3);
      cfg = 3'd2;  step(3); cfg = 3'd4; one_sel = 1'b0; step(3);
      req = "R11"; step(10);

      req = "R3";  vid = 8'h10; step(6);
      req = "R10"; vid = 8'h00; step(6); vid = 8'h18; step(6);

      req = "R4";  auto_en = 1'b0; vid = 8'h40; step(6);
      auto_en = 1'b1; step(6);
      vid = 8'h50; step(6); auto_en = 1'b0; step(4);

      req = "R5";  force_n = 1'b0; step(5); force_n = 1'b1; step(5);
      auto_en = 1'b1; force_n = 1'b0; step(4); force_n = 1'b1; step(4);

      req = "R9";  fmt = 1'b1; step(4);
      vid = 8'h90; step(6);                       // only bits 7:6 differ
      vid = 8'h98; step(6);                       // 6-bit code 0x18: lower
      vid = 8'h05; step(6);                       // higher
      vid = 8'h3F; step(6);                       // 6-bit off code
      fmt = 1'b0; vid = 8'h02; step(6);
      vid = 8'h01; step(6);                       // 8-bit off code

      finish_run();
   end
endmodule